// File: doc/BRIEF.md
# Read Deskew Calibration Sequencer

This block is a hardware state machine that places a receive strobe in the middle of the data eye of a source-synchronous receiver whose transmitter is looped back to it. For every delay knob it steps through all settings. For each setting it issues a write on a delay-register port, waits a programmable settle time, and requests a test-word transfer. It then judges the pass or fail compare result that comes back. It keeps the longest contiguous passing run and finally writes the midpoint of that run back to the knob.

Three phases always run in the same order. The first phase tunes the strobe-enable timing: a coarse delay (one interface clock per step) joined with a fine phase (1/128 of a VCO period per step). The second phase tunes each data pin's input delay (1/256 VCO period per step), one pin after the other. The third phase tunes the strobe input delay, also in 1/256 VCO period steps. When the strobe centre has been written, the block raises a done flag and the interface can be handed to normal traffic. If a knob has no passing setting at all, the block stops and reports which phase failed.

The delay hardware and the loopback path are outside the block. They appear only as a write port, a probe request and a compare response.

Top module: `deskew_seq`

## Requirements
- R1: After reset, busy, cal_done, cal_err, cfg_we and probe_req are 0 and err_code is 0.
- R2: A start pulse while idle begins a run. Writes address knob code 0 (strobe-enable timing), then 1 (data pin delay), then 2 (strobe input delay), and the knob code never decreases within a run.
- R3: The strobe-enable sweep writes values 0 up to 2^EN_W-1 in ascending order. The value holds the coarse delay in its upper EN_CRS_W bits and the fine phase in its lower EN_FINE_W bits. Each setting is judged by the AND of all cmp_pass bits.
- R4: The data phase handles pins 0 to NPIN-1 in ascending order. For each pin it writes 0 up to 2^DQ_W-1 in ascending order on cfg_pin, and each setting is judged by cmp_pass bit [pin] alone.
- R5: The strobe input sweep writes 2^DQS_W-1 down to 0 in descending order, and each setting is judged by the AND of all cmp_pass bits.
- R6: For each sweep write, probe_req rises exactly settle_cycles+2 cycles after the cycle in which cfg_we is high.
- R7: After probe_req the block waits, with no write and no further probe, for as long as cmp_valid stays low. It samples cmp_pass only in the cycle cmp_valid is high.
- R8: The value programmed for a knob is floor((first+last)/2), where first and last are the end settings of the longest contiguous passing run in sweep order. Among runs of equal length, the one met first in sweep order wins.
- R9: After the last setting of a sweep, exactly one extra write carries the centre value for that knob and pin before the next sweep begins.
- R10: If a sweep ends with no passing setting, the block goes idle with no centre write and no further writes or probes. It sets cal_err to 1 and err_code to 1, 2 or 3 for the strobe-enable, data or strobe input phase, and cal_done stays 0.
- R11: cal_done rises only after the strobe input centre write. It stays 1 until the next accepted start, and a start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration run when idle |
| settle_cycles | input | SET_W | Extra wait cycles between a write and its probe |
| cfg_we | output | 1 | Delay register write strobe |
| cfg_knob | output | 2 | Knob code: 0 strobe-enable, 1 data pin, 2 strobe input |
| cfg_pin | output | PIN_W | Data pin index for knob 1, 0 otherwise |
| cfg_val | output | VW | Delay setting being written |
| probe_req | output | 1 | Request one test-word transfer and compare |
| cmp_valid | input | 1 | Compare result is present this cycle |
| cmp_pass | input | NPIN | Per-pin compare pass bits |
| busy | output | 1 | A run is in progress |
| cal_done | output | 1 | Calibration finished successfully |
| cal_err | output | 1 | Calibration stopped on a knob with no passing setting |
| err_code | output | 2 | Phase that failed (1, 2 or 3), 0 otherwise |

## Verification
The hardest outcome to reach from the ports is the choice between competing passing runs: two runs of equal length, or a short isolated pass ahead of a wider window. The descending strobe input sweep reverses which run counts as first. The bench's loopback model gives each knob a programmable passing window plus an optional isolated passing point. Directed runs place a single-point window and a single glitch at mirrored positions so that the tie goes opposite ways for the ascending and descending sweeps. Random runs then scatter windows, glitches, settle times and response latencies, and other directed runs empty one knob at a time to reach each error code.

// File: rtl/deskew_seq.sv
module deskew_seq #(
  parameter int NPIN      = 4,
  parameter int EN_CRS_W  = 2,
  parameter int EN_FINE_W = 3,
  parameter int DQ_W      = 4,
  parameter int DQS_W     = 4,
  parameter int SET_W     = 8,
  localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int EN_W  = EN_CRS_W + EN_FINE_W,
  localparam int VW    = (EN_W > DQ_W) ? ((EN_W > DQS_W) ? EN_W : DQS_W)
                                       : ((DQ_W > DQS_W) ? DQ_W : DQS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SET_W-1:0] settle_cycles,
  output logic             cfg_we,
  output logic [1:0]       cfg_knob,
  output logic [PIN_W-1:0] cfg_pin,
  output logic [VW-1:0]    cfg_val,
  output logic             probe_req,
  input  logic             cmp_valid,
  input  logic [NPIN-1:0]  cmp_pass,
  output logic             busy,
  output logic             cal_done,
  output logic             cal_err,
  output logic [1:0]       err_code
);

  localparam logic [VW-1:0] EN_TOP  = VW'((1 << EN_W) - 1);
  localparam logic [VW-1:0] DQ_TOP  = VW'((1 << DQ_W) - 1);
  localparam logic [VW-1:0] DQS_TOP = VW'((1 << DQS_W) - 1);
  localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NPIN - 1);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_SETTLE, S_PROBE, S_WAIT, S_APPLY} st_t;

  st_t              st;
  logic [1:0]       knob;
  logic [PIN_W-1:0] pin;
  logic [VW-1:0]    cur;
  logic [SET_W-1:0] cnt;
  logic [VW:0]      run_len, best_len;
  logic [VW-1:0]    run_first, best_first, best_last;
  logic             done_q, err_q;
  logic [1:0]       code_q;

  logic          hit, last_step, better;
  logic [VW-1:0] next_val, run_first_n, centre;
  logic [VW:0]   run_len_n, best_len_n, csum;

  assign hit         = (knob == 2'd1) ? cmp_pass[pin] : &cmp_pass;
  assign last_step   = (knob == 2'd2) ? (cur == '0)
                     : (cur == ((knob == 2'd0) ? EN_TOP : DQ_TOP));
  assign next_val    = (knob == 2'd2) ? cur - 1'b1 : cur + 1'b1;
  assign run_len_n   = hit ? run_len + 1'b1 : '0;
  assign run_first_n = (run_len == '0) ? cur : run_first;
  assign better      = hit && (run_len_n > best_len);
  assign best_len_n  = better ? run_len_n : best_len;
  assign csum        = {1'b0, best_first} + {1'b0, best_last};
  assign centre      = csum[VW:1];

  assign busy      = (st != S_IDLE);
  assign cfg_we    = (st == S_WR) || (st == S_APPLY);
  assign cfg_val   = (st == S_APPLY) ? centre : cur;
  assign cfg_knob  = knob;
  assign cfg_pin   = pin;
  assign probe_req = (st == S_PROBE);
  assign cal_done  = done_q;
  assign cal_err   = err_q;
  assign err_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      knob       <= '0;
      pin        <= '0;
      cur        <= '0;
      cnt        <= '0;
      run_len    <= '0;
      run_first  <= '0;
      best_len   <= '0;
      best_first <= '0;
      best_last  <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      code_q     <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          knob     <= '0;
          pin      <= '0;
          cur      <= '0;
          run_len  <= '0;
          best_len <= '0;
          done_q   <= 1'b0;
          err_q    <= 1'b0;
          code_q   <= '0;
          st       <= S_WR;
        end
        S_WR: begin
          cnt <= settle_cycles;
          st  <= S_SETTLE;
        end
        S_SETTLE: begin
          if (cnt == '0) st <= S_PROBE;
          else cnt <= cnt - 1'b1;
        end
        S_PROBE: st <= S_WAIT;
        S_WAIT: if (cmp_valid) begin
          run_len <= run_len_n;
          if (hit) run_first <= run_first_n;
          if (better) begin
            best_len   <= run_len_n;
            best_first <= run_first_n;
            best_last  <= cur;
          end
          if (!last_step) begin
            cur <= next_val;
            st  <= S_WR;
          end else if (best_len_n == '0) begin
            err_q  <= 1'b1;
            code_q <= knob + 2'd1;
            st     <= S_IDLE;
          end else begin
            st <= S_APPLY;
          end
        end
        S_APPLY: begin
          run_len  <= '0;
          best_len <= '0;
          if (knob == 2'd1 && pin != LAST_PIN) begin
            pin <= pin + 1'b1;
            cur <= '0;
            st  <= S_WR;
          end else if (knob == 2'd2) begin
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            knob <= knob + 2'd1;
            pin  <= '0;
            cur  <= (knob == 2'd1) ? DQS_TOP : '0;
            st   <= S_WR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/deskew_seq_chk.sv
module deskew_seq_chk #(
  parameter int SET_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [SET_W-1:0] settle_cycles,
  input logic             cfg_we,
  input logic [1:0]       cfg_knob,
  input logic             probe_req,
  input logic             busy,
  input logic             cal_done,
  input logic             cal_err,
  input logic [1:0]       err_code
);

  logic [SET_W+1:0] gap;
  logic [1:0]       last_knob;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap       <= '1;
      last_knob <= '0;
    end else begin
      if (cfg_we) gap <= '0;
      else if (gap != '1) gap <= gap + 1'b1;
      if (start && !busy) last_knob <= '0;
      else if (cfg_we) last_knob <= cfg_knob;
    end
  end

  p_settle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |-> gap == (SET_W+2)'(settle_cycles) + 1'b1);

  p_knob_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_knob >= last_knob) && (cfg_knob != 2'd3));

  p_wait_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req |=> !cfg_we && !probe_req);

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done && cal_err));

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |-> !cfg_we && !probe_req && !busy && err_code != 2'd0);

  p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done && !start |=> cal_done);

  p_idle_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cal_done && !cal_err);

endmodule

bind deskew_seq deskew_seq_chk #(.SET_W(SET_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
  .cfg_we(cfg_we), .cfg_knob(cfg_knob), .probe_req(probe_req), .busy(busy),
  .cal_done(cal_done), .cal_err(cal_err), .err_code(err_code)
);

// File: tb/sim_deskew_seq.sv
`timescale 1ns/1ps
module sim_deskew_seq;
  localparam int NPIN = 4;
  localparam int EN_N = 32;
  localparam int DQ_N = 16;
  localparam int DQS_N = 16;
  localparam int NW = NPIN + 2;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] settle_cycles = 0;
  logic cfg_we, probe_req, cmp_valid = 0, busy, cal_done, cal_err;
  logic [1:0] cfg_knob, err_code;
  logic [1:0] cfg_pin;
  logic [4:0] cfg_val;
  logic [NPIN-1:0] cmp_pass = '0;

  always #5 clk = ~clk;

  deskew_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
    .cfg_we(cfg_we), .cfg_knob(cfg_knob), .cfg_pin(cfg_pin), .cfg_val(cfg_val),
    .probe_req(probe_req), .cmp_valid(cmp_valid), .cmp_pass(cmp_pass), .busy(busy),
    .cal_done(cal_done), .cal_err(cal_err), .err_code(err_code));

  int n_chk = 0, n_fail = 0;
  int lo[NW], hi[NW], gl[NW];
  int m_en, m_dqs, m_knob;
  int m_dq[NPIN];
  int wcnt[3], fval[3], fseen[3];
  int gap_bad, order_bad, last_we, cyc, last_k;
  int pend, dly, max_lat;
  bit clr;

  function automatic bit ok_at(int w, int v);
    return (v >= lo[w] && v <= hi[w]) || v == gl[w];
  endfunction

  function automatic int nvals(int w);
    return (w == 0) ? EN_N : ((w == NW-1) ? DQS_N : DQ_N);
  endfunction

  function automatic bit exp_centre(int w, output int c);
    int n = nvals(w), rl = 0, rf = 0, bl = 0, bf = 0, bla = 0;
    for (int i = 0; i < n; i++) begin
      int v = (w == NW-1) ? n-1-i : i;
      if (ok_at(w, v)) begin
        if (rl == 0) rf = v;
        rl++;
        if (rl > bl) begin bl = rl; bf = rf; bla = v; end
      end else rl = 0;
    end
    c = (bf + bla) / 2;
    return bl > 0;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    cmp_valid <= 1'b0;
    if (clr) begin
      for (int k = 0; k < 3; k++) begin wcnt[k] <= 0; fseen[k] <= 0; fval[k] <= 0; end
      gap_bad <= 0; order_bad <= 0; last_k <= 0;
    end else begin
      if (cfg_we) begin
        wcnt[cfg_knob] <= wcnt[cfg_knob] + 1;
        if (!fseen[cfg_knob]) begin fseen[cfg_knob] <= 1; fval[cfg_knob] <= cfg_val; end
        if (int'(cfg_knob) < last_k) order_bad <= order_bad + 1;
        last_k <= cfg_knob;
        last_we <= cyc;
        m_knob <= cfg_knob;
        if (cfg_knob == 0) m_en <= cfg_val;
        else if (cfg_knob == 1) m_dq[cfg_pin] <= cfg_val;
        else m_dqs <= cfg_val;
      end
      if (probe_req) begin
        if (cyc - last_we != int'(settle_cycles) + 2) gap_bad <= gap_bad + 1;
        pend <= 1; dly <= $urandom_range(0, max_lat);
      end
    end
    if (pend != 0 && !probe_req) begin
      if (dly == 0) begin
        pend <= 0; cmp_valid <= 1'b1;
        for (int p = 0; p < NPIN; p++)
          cmp_pass[p] <= (m_knob == 0) ? ok_at(0, m_en)
                       : (m_knob == 1) ? ok_at(1+p, m_dq[p]) : ok_at(NW-1, m_dqs);
      end else dly <= dly - 1;
    end
  end

  task automatic chk(bit c, string req, int act, int exp);
    n_chk++;
    if (!c) begin n_fail++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  task automatic set_win(int w, int l, int h, int g);
    lo[w] = l; hi[w] = h; gl[w] = g;
  endtask

  task automatic rand_wins();
    for (int w = 0; w < NW; w++) begin
      int n = nvals(w), l = $urandom_range(0, n-1);
      set_win(w, l, $urandom_range(l, n-1), ($urandom_range(0,1) != 0) ? $urandom_range(0, n-1) : -1);
    end
  endtask

  task automatic run_cal(int settle, bit poke);
    int c, fail_w = -1, t = 0;
    int ew[3];
    settle_cycles = 8'(settle);
    clr = 1; @(negedge clk); clr = 0;
    start = 1; @(negedge clk); start = 0;
    while (!(cal_done || cal_err) && t < 30000) begin
      @(negedge clk); t++;
      if (poke && t == 200) start = 1;
      else start = 0;
    end
    start = 0;
    repeat (20) @(negedge clk);
    for (int w = 0; w < NW && fail_w < 0; w++) if (!exp_centre(w, c)) fail_w = w;
    ew[0] = (fail_w == 0) ? EN_N : EN_N + 1;
    ew[1] = (fail_w == 0) ? 0 : (fail_w < 0 || fail_w == NW-1) ? NPIN*(DQ_N+1) : (fail_w-1)*(DQ_N+1) + DQ_N;
    ew[2] = (fail_w < 0) ? DQS_N + 1 : (fail_w == NW-1) ? DQS_N : 0;
    chk(cal_done == (fail_w < 0), "R11 done", cal_done, fail_w < 0);
    chk(cal_err == (fail_w >= 0), "R10 err flag", cal_err, fail_w >= 0);
    chk(int'(err_code) == ((fail_w < 0) ? 0 : (fail_w == 0) ? 1 : (fail_w == NW-1) ? 3 : 2), "R10 err_code",
        err_code, (fail_w < 0) ? 0 : (fail_w == 0) ? 1 : (fail_w == NW-1) ? 3 : 2);
    for (int k = 0; k < 3; k++) chk(wcnt[k] == ew[k], "R9 write count", wcnt[k], ew[k]);
    chk(gap_bad == 0, "R6 settle gap", gap_bad, 0);
    chk(order_bad == 0, "R2 phase order", order_bad, 0);
    chk(fval[0] == 0, "R3 enable sweep start", fval[0], 0);
    if (fail_w != 0) chk(fval[1] == 0, "R4 data sweep start", fval[1], 0);
    if (fail_w < 0 || fail_w == NW-1) chk(fval[2] == DQS_N-1, "R5 strobe sweep start", fval[2], DQS_N-1);
    if (fail_w < 0) begin
      void'(exp_centre(0, c)); chk(m_en == c, "R8 R3 enable centre", m_en, c);
      for (int p = 0; p < NPIN; p++) begin
        void'(exp_centre(1+p, c)); chk(m_dq[p] == c, "R8 R4 data centre", m_dq[p], c);
      end
      void'(exp_centre(NW-1, c)); chk(m_dqs == c, "R8 R5 strobe centre", m_dqs, c);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s0;
    s0 = $urandom(1234);
    cyc = 0; pend = 0; dly = 0; max_lat = 0; m_en = 0; m_dqs = 0; m_knob = 0;
    for (int p = 0; p < NPIN; p++) m_dq[p] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !cal_done && !cal_err && !cfg_we && !probe_req && err_code == 0, "R1 reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    // R3 R4 R5 wide windows, no settle
    set_win(0, 4, 27, -1);
    for (int p = 0; p < NPIN; p++) set_win(1+p, 2+p, 12, -1);
    set_win(NW-1, 3, 10, -1);
    run_cal(0, 0);
    // R8 tie: ascending keeps lower, descending keeps higher
    set_win(0, 10, 10, 20); set_win(NW-1, 3, 3, 12);
    for (int p = 0; p < NPIN; p++) set_win(1+p, 9, 11, 1);
    max_lat = 3;
    run_cal(3, 0);
    // R11 start ignored while busy
    rand_wins(); for (int w = 0; w < NW; w++) if (lo[w] > hi[w]) lo[w] = hi[w];
    run_cal(1, 1);
    // R10 each phase empty in turn
    set_win(0, 5, 5, -1); set_win(NW-1, 5, 9, -1);
    for (int p = 0; p < NPIN; p++) set_win(1+p, 1, 14, -1);
    set_win(0, 9, 8, -1); run_cal(2, 0);
    set_win(0, 5, 5, -1); set_win(3, 9, 8, -1); run_cal(0, 0);
    set_win(3, 1, 14, -1); set_win(NW-1, 9, 8, -1); run_cal(1, 0);
    // random runs
    for (int r = 0; r < 12; r++) begin
      rand_wins();
      run_cal($urandom_range(0, 5), 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule